// File: doc/BRIEF.md
# Programmable Pulse and One-Shot Timer

This block is a 16-bit up-counter that drives a single pulse output. It runs in one of two ways. As a free-running pulse generator, it repeats a waveform whose period and high time each come from a compare register. As a one-shot, it produces a single pulse when software requests one through a control write, or when a rising edge appears on an external trigger input. A width-match event raises a one-cycle interrupt pulse, which a mask bit can hold back. It also sets a pending flag that software clears by writing a one.

The whole block runs on the system clock. The count rate comes from a one-cycle enable strobe (`cnt_en`) that a prescaler outside the block produces. Software programs the block through a simple write port with three used addresses. It can reprogram the width while the block is running. The new width is staged, so it never lands in the middle of a count step.

Top module: `pulse_timer16`

## Requirements
- R1: After reset the count is 0, the pulse output is low, the interrupt and pending flag are low, the period register holds FFFFH and the width register holds 7FFFH, so the configuration error flag is low.
- R2: Control bits [1:0] select the mode: 00 stop, 01 free-running pulse generator, 10 one-shot triggered by software or external edge, 11 one-shot triggered by external edge only. Mode 00 holds the count at 0 and the output low. A control write that changes the mode restarts the block: count 0, output low, no pulse active. A strobe in the same cycle as that write is not counted, so counting starts on the first strobe after the write.
- R3: In mode 01 the output goes high on the strobe where the count equals the period value and the count returns to 0. It goes low on the strobe where the count equals the width value. This gives a period of (period+1) strobes and a high time of (width+1) strobes.
- R4: The count changes only on a strobe, by +1, or to 0 on a period match; with no strobe, no write and no trigger it holds.
- R5: Control bit 2 enables the drop of the output on a width match; with it 0 the output stays high once set, until a period match in one-shot mode or a restart.
- R6: A write to the width register (address 1) is staged. The compare uses the previous width for the first two strobes after the write and uses the new width from the third strobe onward.
- R7: In mode 10, a control write with bit 4 set (and bits [1:0] unchanged) starts a pulse: count 0, output high at once. The output drops on the width match. The pulse ends on the period match, which returns the count to 0 and forces the output low.
- R8: A software or external trigger that arrives while a one-shot pulse is active does not restart the count; counting continues.
- R9: A rising edge on `ext_trig` starts a one-shot in both mode 10 and mode 11; in mode 11 the software trigger bit has no effect.
- R10: Each width match raises `irq_o` for exactly one cycle, in the cycle after the matching strobe, unless control bit 3 (mask) is 1. Every match sets `irq_pend_o` whatever the mask. A control write with bit 5 set clears it, and a match in the same cycle wins over the clear.
- R11: `cfg_err_o` is high whenever the programmed period is 0, the programmed width is 0, or the width is not below the period.
- R12: Address 0 writes the period, address 1 the width, address 2 the control fields; a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count strobe, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| ext_trig | input | 1 | External one-shot trigger, rising edge active |
| pulse_o | output | 1 | Timer pulse output |
| irq_o | output | 1 | Width-match interrupt pulse |
| irq_pend_o | output | 1 | Width-match pending flag |
| cfg_err_o | output | 1 | Illegal period/width programming |
| count_o | output | 16 | Current counter value |

## Verification
The assertions expect `ext_trig`, `wr_*` and `cnt_en` to be synchronous to `clk` and stable around the edge. They make no assumption about legal programming, so they also hold when the width is not below the period. The stimulus changes every input just after a rising edge. It holds external trigger pulses for single cycles, and it keeps the period and width legal except in the short windows that test the configuration error flag. A behavioural model in the bench follows the register map, the staging delay and the trigger priority cycle by cycle, and the bench compares every output against it on every clock.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  // control field bit positions
  localparam int CB_INV    = 2;
  localparam int CB_MASK   = 3;
  localparam int CB_SWTRIG = 4;
  localparam int CB_PCLR   = 5;

  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_PPG    = 2'b01,
    MODE_OS_ANY = 2'b10,
    MODE_OS_EXT = 2'b11
  } pt_mode_e;

  typedef struct packed {
    logic     mask;
    logic     inv_en;
    pt_mode_e mode;
  } pt_ctrl_t;

  function automatic logic is_oneshot(input pt_mode_e m);
    return (m == MODE_OS_ANY) || (m == MODE_OS_EXT);
  endfunction

endpackage

// File: rtl/pt_regs.sv
module pt_regs
  import pt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     period,
  output logic [CW-1:0]     width_act,
  output pt_ctrl_t          ctrl,
  output logic              restart,
  output logic              sw_trig_wr,
  output logic              pend_clr,
  output logic              cfg_err
);

  localparam logic [CW-1:0] PER_RST = '1;
  localparam logic [CW-1:0] WID_RST = PER_RST >> 1;

  function automatic logic cfg_bad(input logic [CW-1:0] per, input logic [CW-1:0] wid);
    return (per == '0) || (wid == '0) || (wid >= per);
  endfunction

  logic [CW-1:0] per_q;
  logic [CW-1:0] wid_wr_q;
  logic [CW-1:0] wid_act_q;
  logic          stg_pend_q;
  logic          stg_arm_q;
  pt_ctrl_t      ctrl_q;

  logic     wr_per, wr_wid, wr_ctl;
  pt_mode_e new_mode;

  assign wr_per   = wr_en && (wr_addr == A_PERIOD);
  assign wr_wid   = wr_en && (wr_addr == A_WIDTH);
  assign wr_ctl   = wr_en && (wr_addr == A_CTRL);
  assign new_mode = pt_mode_e'(wr_data[1:0]);

  assign restart    = wr_ctl && (new_mode != ctrl_q.mode);
  assign sw_trig_wr = wr_ctl && wr_data[CB_SWTRIG];
  assign pend_clr   = wr_ctl && wr_data[CB_PCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= PER_RST;
      ctrl_q <= '{mask: 1'b0, inv_en: 1'b0, mode: MODE_STOP};
    end else begin
      if (wr_per) per_q <= wr_data;
      if (wr_ctl) begin
        ctrl_q.mode   <= new_mode;
        ctrl_q.inv_en <= wr_data[CB_INV];
        ctrl_q.mask   <= wr_data[CB_MASK];
      end
    end
  end

  // width staging: arm on the first strobe after a write, load on the second
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid_wr_q   <= WID_RST;
      wid_act_q  <= WID_RST;
      stg_pend_q <= 1'b0;
      stg_arm_q  <= 1'b0;
    end else if (wr_wid) begin
      wid_wr_q   <= wr_data;
      stg_pend_q <= 1'b1;
      stg_arm_q  <= 1'b0;
    end else if (tick && stg_pend_q) begin
      if (stg_arm_q) begin
        wid_act_q  <= wid_wr_q;
        stg_pend_q <= 1'b0;
        stg_arm_q  <= 1'b0;
      end else begin
        stg_arm_q <= 1'b1;
      end
    end
  end

  assign period    = per_q;
  assign width_act = wid_act_q;
  assign ctrl      = ctrl_q;
  assign cfg_err   = cfg_bad(per_q, wid_wr_q);

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_wid) |=> $stable(wid_act_q)); // R6

  AST_WIDTH_NOT_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wid |=> $stable(wid_act_q)); // R6

  AST_ADDR3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(per_q) && $stable(ctrl_q) && $stable(wid_wr_q))); // R12

endmodule

// File: rtl/pt_trig.sv
module pt_trig
  import pt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_trig,
  input  pt_mode_e mode,
  input  logic     os_active,
  input  logic     sw_trig_wr,
  input  logic     restart,
  output logic     ext_edge,
  output logic     trig_req,
  output logic     trig_fire
);

  logic ext_prev_q;

  function automatic logic wants_start(input pt_mode_e m, input logic sw, input logic ed);
    return (sw && (m == MODE_OS_ANY)) || (ed && is_oneshot(m));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_trig;
  end

  assign ext_edge  = ext_trig && !ext_prev_q;
  assign trig_req  = wants_start(mode, sw_trig_wr, ext_edge);
  assign trig_fire = trig_req && !os_active && !restart;

endmodule

// File: rtl/pt_core.sv
module pt_core
  import pt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  pt_mode_e      mode,
  input  logic          inv_en,
  input  logic          mask,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] width,
  input  logic          restart,
  input  logic          trig_fire,
  input  logic          pend_clr,
  output logic [CW-1:0] count,
  output logic          pulse,
  output logic          os_active,
  output logic          irq,
  output logic          irq_pend,
  output logic          wm_evt,
  output logic          pm_evt
);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic          os_q;
  logic          irq_q;
  logic          pend_q;
  logic          running;
  logic          step;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c, input logic wrap);
    return wrap ? '0 : c + CW'(1);
  endfunction

  assign running = (mode == MODE_PPG) || (is_oneshot(mode) && os_q);
  assign step    = tick && running && !restart && !trig_fire;
  assign pm_evt  = step && (cnt_q == period);
  assign wm_evt  = step && (cnt_q == width);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      os_q    <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      irq_q  <= wm_evt && !mask;
      pend_q <= wm_evt || (pend_q && !pend_clr);
      if (restart) begin
        cnt_q   <= '0;
        pulse_q <= 1'b0;
        os_q    <= 1'b0;
      end else if (trig_fire) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
        os_q    <= 1'b1;
      end else if (step) begin
        cnt_q <= next_count(cnt_q, pm_evt);
        if (pm_evt) begin
          pulse_q <= (mode == MODE_PPG);
          if (mode != MODE_PPG) os_q <= 1'b0;
        end else if (wm_evt && inv_en) begin
          pulse_q <= 1'b0;
        end
      end
    end
  end

  assign count     = cnt_q;
  assign pulse     = pulse_q;
  assign os_active = os_q;
  assign irq       = irq_q;
  assign irq_pend  = pend_q;

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP) |-> (cnt_q == '0 && !pulse_q)); // R2

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !pulse_q && !os_q)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !trig_fire) |=> $stable(cnt_q)); // R4

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pm_evt |=> (cnt_q == '0)); // R3

  AST_PPG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_evt && mode == MODE_PPG) |=> pulse_q); // R3

  AST_WIDTH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_evt && !pm_evt && inv_en) |=> !pulse_q); // R5

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (pulse_q && os_q && cnt_q == '0)); // R7

  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_evt && mode != MODE_PPG) |=> (!os_q && !pulse_q)); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(wm_evt) && !$past(mask))); // R10

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wm_evt |=> pend_q); // R10

endmodule

// File: rtl/pulse_timer16.sv
module pulse_timer16
  import pt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ext_trig,
  output logic              pulse_o,
  output logic              irq_o,
  output logic              irq_pend_o,
  output logic              cfg_err_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [CNT_W-1:0] period, width_act;
  pt_ctrl_t         ctrl;
  logic             restart, sw_trig_wr, pend_clr;
  logic             ext_edge, trig_req, trig_fire;
  logic             os_active, wm_evt, pm_evt;

  pt_regs #(.CW(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .period     (period),
    .width_act  (width_act),
    .ctrl       (ctrl),
    .restart    (restart),
    .sw_trig_wr (sw_trig_wr),
    .pend_clr   (pend_clr),
    .cfg_err    (cfg_err_o)
  );

  pt_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_trig   (ext_trig),
    .mode       (ctrl.mode),
    .os_active  (os_active),
    .sw_trig_wr (sw_trig_wr),
    .restart    (restart),
    .ext_edge   (ext_edge),
    .trig_req   (trig_req),
    .trig_fire  (trig_fire)
  );

  pt_core #(.CW(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cnt_en),
    .mode      (ctrl.mode),
    .inv_en    (ctrl.inv_en),
    .mask      (ctrl.mask),
    .period    (period),
    .width     (width_act),
    .restart   (restart),
    .trig_fire (trig_fire),
    .pend_clr  (pend_clr),
    .count     (count_o),
    .pulse     (pulse_o),
    .os_active (os_active),
    .irq       (irq_o),
    .irq_pend  (irq_pend_o),
    .wm_evt    (wm_evt),
    .pm_evt    (pm_evt)
  );

  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (os_active && trig_req && !restart && !cnt_en) |=> $stable(count_o)); // R8

  AST_RETRIG_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (os_active && trig_req && !restart && cnt_en && !pm_evt) |=> (count_o == $past(count_o) + CNT_W'(1))); // R8

  AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge); // R9

endmodule

// File: tb/sim_pulse_timer16.sv
module sim_pulse_timer16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        ext_trig;
  logic        pulse_o, irq_o, irq_pend_o, cfg_err_o;
  logic [15:0] count_o;

  int checks = 0;
  int failures = 0;
  int en_div = 1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_trig(ext_trig), .pulse_o(pulse_o), .irq_o(irq_o),
    .irq_pend_o(irq_pend_o), .cfg_err_o(cfg_err_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_per, m_wwr, m_wact, m_mode;
  bit m_out, m_act, m_irq, m_pend, m_inv, m_mask, m_wpend, m_warm, m_prev;

  function automatic bit m_cfg();
    return (m_per == 0) || (m_wwr == 0) || (m_wwr >= m_per);
  endfunction

  always @(posedge clk) begin
    bit cw, rs, sw, ed, tg, run, wm, pm;
    if (!rst_n) begin
      m_cnt = 0; m_per = 65535; m_wwr = 32767; m_wact = 32767; m_mode = 0;
      m_out = 0; m_act = 0; m_irq = 0; m_pend = 0; m_inv = 0; m_mask = 0;
      m_wpend = 0; m_warm = 0; m_prev = 0;
    end else begin
      cw  = wr_en && (wr_addr == 2'd2);
      rs  = cw && (int'(wr_data[1:0]) != m_mode);
      ed  = ext_trig && !m_prev;
      sw  = cw && wr_data[4] && (m_mode == 2);
      tg  = (sw || (ed && m_mode >= 2)) && !m_act && !rs;
      run = (m_mode == 1) || (m_mode >= 2 && m_act);
      wm  = cnt_en && run && !rs && !tg && (m_cnt == m_wact);
      pm  = cnt_en && run && !rs && !tg && (m_cnt == m_per);
      m_irq = wm && !m_mask;
      if (wm) m_pend = 1;
      else if (cw && wr_data[5]) m_pend = 0;
      if (rs) begin
        m_cnt = 0; m_out = 0; m_act = 0;
      end else if (tg) begin
        m_cnt = 0; m_out = 1; m_act = 1;
      end else if (cnt_en && run) begin
        if (pm) begin
          m_cnt = 0;
          m_out = (m_mode == 1);
          if (m_mode != 1) m_act = 0;
        end else begin
          m_cnt = (m_cnt + 1) % 65536;
          if (wm && m_inv) m_out = 0;
        end
      end
      if (wr_en && wr_addr == 2'd0) m_per = int'(wr_data);
      if (wr_en && wr_addr == 2'd1) begin
        m_wwr = int'(wr_data); m_wpend = 1; m_warm = 0;
      end else if (cnt_en && m_wpend) begin
        if (m_warm) begin m_wact = m_wwr; m_wpend = 0; m_warm = 0; end
        else m_warm = 1;
      end
      if (cw) begin
        m_mode = int'(wr_data[1:0]); m_inv = wr_data[2]; m_mask = wr_data[3];
      end
      m_prev = ext_trig;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 count vs model", int'(count_o), m_cnt);
      chk("R3 pulse vs model", int'(pulse_o), int'(m_out));
      chk("R10 irq vs model", int'(irq_o), int'(m_irq));
      chk("R10 pending vs model", int'(irq_pend_o), int'(m_pend));
      chk("R11 cfg_err vs model", int'(cfg_err_o), int'(m_cfg()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0;
  endtask

  initial begin
    cnt_en = 1'b0;
    forever begin
      @(posedge clk); #1;
      cnt_en = (en_div > 0) && (($time / 5) % en_div == 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, lo, seen;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0; ext_trig = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 pulse", int'(pulse_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 pend", int'(irq_pend_o), 0);
    chk("R1 cfg_err", int'(cfg_err_o), 0);
    cyc(3);
    chk("R2 stop holds count", int'(count_o), 0);

    // R11 configuration error cases, R12 addressing
    wr(2'd0, 16'd9); wr(2'd1, 16'd3); cyc(3);
    chk("R11 legal config", int'(cfg_err_o), 0);
    wr(2'd1, 16'd9);
    chk("R11 width equals period", int'(cfg_err_o), 1);
    wr(2'd1, 16'd3); cyc(3);
    wr(2'd0, 16'd0);
    chk("R11 period zero", int'(cfg_err_o), 1);
    wr(2'd0, 16'd9);
    chk("R11 restored", int'(cfg_err_o), 0);

    // R2 start: strobe on write cycle not counted
    wr(2'd2, 16'h0005);
    chk("R2 count after start write", int'(count_o), 0);
    cyc(1);
    chk("R2 first strobe counts", int'(count_o), 1);

    // R3 waveform measurement
    for (int i = 0; i < 30 && !pulse_o; i++) cyc(1);
    hi = 0; while (pulse_o && hi < 50) begin hi++; cyc(1); end
    lo = 0; while (!pulse_o && lo < 50) begin lo++; cyc(1); end
    chk("R3 high time width+1", hi, 4);
    chk("R3 low time period-width", lo, 6);
    chk("R10 pending after matches", int'(irq_pend_o), 1);

    // R4 sparse strobes
    en_div = 3; cyc(40); en_div = 1;
    chk("R4 count within period", int'(count_o <= 16'd9), 1);

    // R5 width drop disabled
    wr(2'd2, 16'h0001); cyc(12);
    seen = 0;
    for (int i = 0; i < 12; i++) begin if (!pulse_o) seen++; cyc(1); end
    chk("R5 output stays high", seen, 0);

    // R6 staged width rewrite
    wr(2'd2, 16'h0000); wr(2'd2, 16'h0005);
    wr(2'd1, 16'd6);
    for (int i = 0; i < 30 && !pulse_o; i++) cyc(1);
    hi = 0; while (pulse_o && hi < 50) begin hi++; cyc(1); end
    chk("R6 new width high time", hi, 7);
    wr(2'd1, 16'd3);

    // R2 stop with pending clear
    wr(2'd2, 16'h0020);
    chk("R2 stop count", int'(count_o), 0);
    chk("R2 stop pulse", int'(pulse_o), 0);
    chk("R10 pending cleared", int'(irq_pend_o), 0);
    cyc(4);
    chk("R2 stop still zero", int'(count_o), 0);

    // R10 masked
    wr(2'd2, 16'h000D);
    seen = 0;
    for (int i = 0; i < 25; i++) begin cyc(1); if (irq_o) seen++; end
    chk("R10 masked irq", seen, 0);
    chk("R10 masked still pends", int'(irq_pend_o), 1);
    wr(2'd2, 16'h0020);
    chk("R10 clear on stop write", int'(irq_pend_o), 0);
    // R10 unmasked count
    wr(2'd2, 16'h0005);
    seen = 0;
    for (int i = 0; i < 25; i++) begin cyc(1); if (irq_o) seen++; end
    chk("R10 one cycle per match", seen, 3);
    wr(2'd2, 16'h0020);

    // R7 software one-shot
    wr(2'd2, 16'h0006); cyc(2);
    chk("R7 idle pulse", int'(pulse_o), 0);
    chk("R7 idle count", int'(count_o), 0);
    wr(2'd2, 16'h0016);
    chk("R7 trigger raises", int'(pulse_o), 1);
    chk("R7 trigger clears count", int'(count_o), 0);
    cyc(2);
    // R8 retriggers ignored
    wr(2'd2, 16'h0016);
    chk("R8 soft retrigger ignored", int'(count_o), 3);
    chk("R8 pulse still high", int'(pulse_o), 1);
    ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    chk("R8 ext retrigger ignored", int'(count_o), 4);
    chk("R7 width drop", int'(pulse_o), 0);
    cyc(10);
    chk("R7 pulse ended", int'(pulse_o), 0);
    chk("R7 count back to zero", int'(count_o), 0);

    // R9 external edge in mode 10
    ext_trig = 1'b1; cyc(1);
    chk("R9 ext start mode10", int'(pulse_o), 1);
    ext_trig = 1'b0; cyc(12);
    // R9 mode 11
    wr(2'd2, 16'h0007);
    wr(2'd2, 16'h0017);
    chk("R9 soft ignored mode11 pulse", int'(pulse_o), 0);
    chk("R9 soft ignored mode11 count", int'(count_o), 0);
    ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    chk("R9 ext start mode11", int'(pulse_o), 1);
    cyc(12);

    // R12 address 3 inert
    wr(2'd3, 16'hFFFF);
    chk("R12 addr3 cfg", int'(cfg_err_o), 0);
    chk("R12 addr3 pulse", int'(pulse_o), 0);
    ext_trig = 1'b1; cyc(1); ext_trig = 1'b0;
    cyc(3);
    chk("R12 width kept high", int'(pulse_o), 1);
    cyc(1);
    chk("R12 width kept drop", int'(pulse_o), 0);
    cyc(8);
    wr(2'd2, 16'h0020);
    cyc(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule